// File: doc/BRIEF.md
# Staged Channel Configuration Commit Engine

This block holds the configuration of a set of threshold-monitoring slots (eight by default). Software does not write the slots directly. It writes one shared staging window through a byte-wide register port. It names the destination slot inside that window, raises a handshake flag and then issues a commit request. On an accepted request the engine copies the whole staged record into the named slot in a single clock edge. After a fixed, parameterised delay it drops the handshake flag, and software polls that flag before it queues the next commit.

The slot records drive the comparison datapath through a flat output bus. That datapath reports threshold crossings back as per-slot low and high event pulses. A pulse is latched into a low or high status byte only when the slot is measuring and the matching interrupt enable is set. Each status byte has two views. In the set view, a write sets bits. In the clear view, writing back the value that was read clears those bits. A slot is switched off by committing a record whose measurement and interrupt enables are all zero.

Top module: `adc_cmt_top`

## Requirements
- R1: After a synchronous active-low reset:
  - all slot records are zero;
  - both status bytes read zero;
  - the handshake flag reads zero at 0x0D and 0x0E;
  - the block-enable bit (0x46 bit 7) is clear;
  - `irq_o` is low.
- R2: The staging window reads back what was written, masked to its defined fields, and unmapped bits read zero. The fields are:
  - 0x40: ID byte.
  - 0x41: target slot in bits 7:5 and interval select in bits 3:2.
  - 0x42: calibration select in bits 5:4 and decimation in bits 3:2.
  - 0x43: averaging byte, with bit 7 as the averaging enable.
  - 0x44: ADC input.
  - 0x45: settle delay in bits 3:0.
  - Thresholds, little-endian: low at 0x49 (low byte) and 0x4A (high byte), high at 0x4B (low byte) and 0x4C (high byte).
  - 0x4D: measurement enable in bit 7, high interrupt enable in bit 1 and low interrupt enable in bit 0.
- R3: A commit request (write to 0x47 with bit 7 set) is accepted only when three conditions hold: block enable is set, the handshake flag is set, and no commit is in progress.
  - An accepted request copies every staged field, in one edge, into the slot named by 0x41 bits 7:5.
  - Other slots are unchanged.
  - The slot record on `slot_cfg_o` is the packed record `slot_t`, most significant field first: id[8], interval[2], cal[2], dec[2], avg[8], adc[8], settle[4], low threshold[16], high threshold[16], meas_en, hi_ie, lo_ie.
  - Slot i occupies bits [i*69 +: 69].
- R4: Writing 0x0D with bit 0 set raises the handshake flag. After an accepted commit on clock edge E, the flag stays set through edge E+HS_DELAY-1 and is cleared by edge E+HS_DELAY.
- R5: A commit request is ignored in two cases, and the slots keep their contents in both:
  - it arrives while an earlier commit is still counting down;
  - it arrives while the handshake flag is clear.
- R6: A commit request made while block enable is clear is ignored. The slots are unchanged and the handshake flag stays as it was.
- R7: Reads of 0x0E return the handshake flag in bit 0. Writing 0x0E with bit 0 set clears the flag and cancels any countdown in progress.
- R8: Committing a record whose measurement and both interrupt enables are zero disables that slot. Later event pulses for that slot set no status bit.
- R9: Status latching:
  - An event pulse on `evt_lo_i[i]` or `evt_hi_i[i]` sets status bit i of the low or high status byte.
  - It does so only when slot i has meas_en and the matching interrupt enable set.
  - Reads of 0x09 and 0x0A return the low status byte; reads of 0x0B and 0x0C return the high status byte.
  - `irq_o` is high whenever any status bit is set.
- R10: Writing 0x09 or 0x0B sets the written 1 bits in the low or high status byte. Writing 0x0A or 0x0C clears the written 1 bits in that byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| evt_lo_i | input | NSLOT | Per-slot low-threshold crossing pulse |
| evt_hi_i | input | NSLOT | Per-slot high-threshold crossing pulse |
| slot_cfg_o | output | NSLOT*69 | Committed slot records, packed |
| irq_o | output | 1 | Any status bit set |

## Verification
The hardest case to reach is a second commit request that lands while the first commit's countdown is still running. The flag is still set at that point, so only the busy state keeps the request out. The stimulus fires the commit, rewrites the target slot field and issues another request, all within the HS_DELAY window. It then checks that the newly named slot stays empty. Refusal while the block is disabled is brought out by checking that the flag is still raised afterwards, and the software abort is then used to lower it.

// File: rtl/adc_cmt_pkg.sv
// Package: shared slot record and register offsets for the commit engine.
// Assumes byte-wide register access and at most eight slots.
package adc_cmt_pkg;
    typedef struct packed {
        logic [7:0]  id;
        logic [1:0]  interval;
        logic [1:0]  cal;
        logic [1:0]  dec;
        logic [7:0]  avg;
        logic [7:0]  adc;
        logic [3:0]  settle;
        logic [15:0] lo_thr;
        logic [15:0] hi_thr;
        logic        meas_en;
        logic        hi_ie;
        logic        lo_ie;
    } slot_t;

    localparam int SLOT_W = $bits(slot_t);

    localparam logic [7:0] A_LO_SET  = 8'h09;
    localparam logic [7:0] A_LO_CLR  = 8'h0A;
    localparam logic [7:0] A_HI_SET  = 8'h0B;
    localparam logic [7:0] A_HI_CLR  = 8'h0C;
    localparam logic [7:0] A_HS_SET  = 8'h0D;
    localparam logic [7:0] A_HS_CLR  = 8'h0E;
    localparam logic [7:0] A_ID      = 8'h40;
    localparam logic [7:0] A_CHCTL   = 8'h41;
    localparam logic [7:0] A_DIG     = 8'h42;
    localparam logic [7:0] A_AVG     = 8'h43;
    localparam logic [7:0] A_ADC     = 8'h44;
    localparam logic [7:0] A_SETTLE  = 8'h45;
    localparam logic [7:0] A_ENABLE  = 8'h46;
    localparam logic [7:0] A_REQ     = 8'h47;
    localparam logic [7:0] A_LO0     = 8'h49;
    localparam logic [7:0] A_LO1     = 8'h4A;
    localparam logic [7:0] A_HI0     = 8'h4B;
    localparam logic [7:0] A_HI1     = 8'h4C;
    localparam logic [7:0] A_MCTL    = 8'h4D;
endpackage

// File: rtl/adc_cmt_stage.sv
// Module: staging window and block-enable register.
// Holds the shared fields software writes before a commit and presents
// them as one slot record plus the target slot number.
// Assumes a write strobe of one cycle per byte; read data is combinational.
module adc_cmt_stage
    import adc_cmt_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [7:0]       addr,
    input  logic [7:0]       wdata,
    output slot_t            staged,
    output logic [SEL_W-1:0] tgt,
    output logic             blk_en,
    output logic [7:0]       rdata
);
    logic [7:0] id_q, avg_q, adc_q, lo0_q, lo1_q, hi0_q, hi1_q;
    logic [2:0] tgt_q;
    logic [1:0] intv_q, cal_q, dec_q;
    logic [3:0] settle_q;
    logic       meas_q, hie_q, lie_q, en_q;

    // Capture staging bytes, keeping only their defined fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q <= '0; avg_q <= '0; adc_q <= '0;
            lo0_q <= '0; lo1_q <= '0; hi0_q <= '0; hi1_q <= '0;
            tgt_q <= '0; intv_q <= '0; cal_q <= '0; dec_q <= '0;
            settle_q <= '0; meas_q <= 1'b0; hie_q <= 1'b0; lie_q <= 1'b0;
            en_q <= 1'b0;
        end else if (wr) begin
            case (addr)
                A_ID:     id_q <= wdata;
                A_CHCTL:  begin tgt_q <= wdata[7:5]; intv_q <= wdata[3:2]; end
                A_DIG:    begin cal_q <= wdata[5:4]; dec_q <= wdata[3:2]; end
                A_AVG:    avg_q <= wdata;
                A_ADC:    adc_q <= wdata;
                A_SETTLE: settle_q <= wdata[3:0];
                A_ENABLE: en_q <= wdata[7];
                A_LO0:    lo0_q <= wdata;
                A_LO1:    lo1_q <= wdata;
                A_HI0:    hi0_q <= wdata;
                A_HI1:    hi1_q <= wdata;
                A_MCTL:   begin meas_q <= wdata[7]; hie_q <= wdata[1]; lie_q <= wdata[0]; end
                default:  ;
            endcase
        end
    end

    // Assemble the staged record from the held fields.
    always_comb begin
        staged.id       = id_q;
        staged.interval = intv_q;
        staged.cal      = cal_q;
        staged.dec      = dec_q;
        staged.avg      = avg_q;
        staged.adc      = adc_q;
        staged.settle   = settle_q;
        staged.lo_thr   = {lo1_q, lo0_q};
        staged.hi_thr   = {hi1_q, hi0_q};
        staged.meas_en  = meas_q;
        staged.hi_ie    = hie_q;
        staged.lo_ie    = lie_q;
    end

    assign tgt    = tgt_q[SEL_W-1:0];
    assign blk_en = en_q;

    // Read-back of the staging window and enable register.
    always_comb begin
        case (addr)
            A_ID:     rdata = id_q;
            A_CHCTL:  rdata = {tgt_q, 1'b0, intv_q, 2'b00};
            A_DIG:    rdata = {2'b00, cal_q, dec_q, 2'b00};
            A_AVG:    rdata = avg_q;
            A_ADC:    rdata = adc_q;
            A_SETTLE: rdata = {4'h0, settle_q};
            A_ENABLE: rdata = {en_q, 7'h00};
            A_LO0:    rdata = lo0_q;
            A_LO1:    rdata = lo1_q;
            A_HI0:    rdata = hi0_q;
            A_HI1:    rdata = hi1_q;
            A_MCTL:   rdata = {meas_q, 5'h00, hie_q, lie_q};
            default:  rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/adc_cmt_hs.sv
// Module: handshake flag and commit sequencer.
// Accepts a commit only when enabled, flagged and idle; then counts
// HS_DELAY cycles and drops the flag. A software abort clears flag and count.
// Assumes HS_DELAY >= 1.
module adc_cmt_hs #(
    parameter int HS_DELAY = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_set,
    input  logic hs_abort,
    input  logic req,
    input  logic blk_en,
    output logic hs_flag,
    output logic commit_go
);
    localparam int CNT_W = $clog2(HS_DELAY + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             flag_q;

    assign commit_go = req && blk_en && flag_q && !busy_q;
    assign hs_flag   = flag_q;

    // Sequence: abort wins, then accept, then count down, then software set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            flag_q <= 1'b0;
        end else if (hs_abort) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            flag_q <= 1'b0;
        end else if (commit_go) begin
            cnt_q  <= CNT_W'(HS_DELAY);
            busy_q <= 1'b1;
        end else if (busy_q) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
                busy_q <= 1'b0;
                flag_q <= 1'b0;
            end
        end else if (hs_set) begin
            flag_q <= 1'b1;
        end
    end
endmodule

// File: rtl/adc_cmt_slots.sv
// Module: bank of committed slot records.
// Each slot loads the staged record on a commit aimed at it.
module adc_cmt_slots
    import adc_cmt_pkg::*;
#(
    parameter int NSLOT = 8,
    parameter int SEL_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    commit_go,
    input  logic [SEL_W-1:0]        tgt,
    input  slot_t                   staged,
    output logic [NSLOT*SLOT_W-1:0] slots_flat,
    output logic [NSLOT-1:0]        lo_gate,
    output logic [NSLOT-1:0]        hi_gate
);
    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        slot_t rec_q;

        // Load this slot when the commit names it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rec_q <= '0;
            else if (commit_go && (tgt == SEL_W'(i)))
                rec_q <= staged;
        end

        assign slots_flat[i*SLOT_W +: SLOT_W] = rec_q;
        assign lo_gate[i] = rec_q.meas_en && rec_q.lo_ie;
        assign hi_gate[i] = rec_q.meas_en && rec_q.hi_ie;
    end
endmodule

// File: rtl/adc_cmt_status.sv
// Module: one status byte with set and clear views.
// Software set/clear are applied first; gated events are OR-ed in last,
// so an event in the same cycle as a clear survives.
module adc_cmt_status #(
    parameter int NSLOT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSLOT-1:0] evt,
    input  logic [NSLOT-1:0] gate,
    input  logic             set_wr,
    input  logic             clr_wr,
    input  logic [NSLOT-1:0] wbits,
    output logic [NSLOT-1:0] st
);
    // Update status bits from software views and qualified events.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= '0;
        else
            st <= ((st | (set_wr ? wbits : '0)) & ~(clr_wr ? wbits : '0)) | (evt & gate);
    end
endmodule

// File: rtl/adc_cmt_top.sv
// Module: staged channel configuration commit engine (top).
// Decodes the byte register port, routes the staging window, handshake,
// slot bank and status bytes, and muxes read data.
// Assumes NSLOT <= 8 so each slot maps to one status bit.
module adc_cmt_top
    import adc_cmt_pkg::*;
#(
    parameter int NSLOT    = 8,
    parameter int HS_DELAY = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic [7:0]              bus_addr,
    input  logic [7:0]              bus_wdata,
    output logic [7:0]              bus_rdata,
    input  logic [NSLOT-1:0]        evt_lo_i,
    input  logic [NSLOT-1:0]        evt_hi_i,
    output logic [NSLOT*SLOT_W-1:0] slot_cfg_o,
    output logic                    irq_o
);
    localparam int SEL_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;

    slot_t            staged;
    logic [SEL_W-1:0] tgt;
    logic             blk_en, hs_flag, commit_go;
    logic [7:0]       stage_rdata;
    logic [NSLOT-1:0] lo_gate, hi_gate, st_lo, st_hi;

    adc_cmt_stage #(.SEL_W(SEL_W)) u_stage (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .staged(staged), .tgt(tgt), .blk_en(blk_en), .rdata(stage_rdata)
    );

    adc_cmt_hs #(.HS_DELAY(HS_DELAY)) u_hs (
        .clk(clk), .rst_n(rst_n),
        .hs_set  (bus_wr && bus_addr == A_HS_SET && bus_wdata[0]),
        .hs_abort(bus_wr && bus_addr == A_HS_CLR && bus_wdata[0]),
        .req     (bus_wr && bus_addr == A_REQ && bus_wdata[7]),
        .blk_en(blk_en), .hs_flag(hs_flag), .commit_go(commit_go)
    );

    adc_cmt_slots #(.NSLOT(NSLOT), .SEL_W(SEL_W)) u_slots (
        .clk(clk), .rst_n(rst_n), .commit_go(commit_go), .tgt(tgt), .staged(staged),
        .slots_flat(slot_cfg_o), .lo_gate(lo_gate), .hi_gate(hi_gate)
    );

    adc_cmt_status #(.NSLOT(NSLOT)) u_st_lo (
        .clk(clk), .rst_n(rst_n), .evt(evt_lo_i), .gate(lo_gate),
        .set_wr(bus_wr && bus_addr == A_LO_SET), .clr_wr(bus_wr && bus_addr == A_LO_CLR),
        .wbits(bus_wdata[NSLOT-1:0]), .st(st_lo)
    );

    adc_cmt_status #(.NSLOT(NSLOT)) u_st_hi (
        .clk(clk), .rst_n(rst_n), .evt(evt_hi_i), .gate(hi_gate),
        .set_wr(bus_wr && bus_addr == A_HI_SET), .clr_wr(bus_wr && bus_addr == A_HI_CLR),
        .wbits(bus_wdata[NSLOT-1:0]), .st(st_hi)
    );

    assign irq_o = |{st_lo, st_hi};

    // Read mux: status and handshake views, else the staging window.
    always_comb begin
        bus_rdata = 8'h00;
        case (bus_addr)
            A_LO_SET, A_LO_CLR: bus_rdata[NSLOT-1:0] = st_lo;
            A_HI_SET, A_HI_CLR: bus_rdata[NSLOT-1:0] = st_hi;
            A_HS_SET, A_HS_CLR: bus_rdata[0] = hs_flag;
            default:            bus_rdata = stage_rdata;
        endcase
    end
endmodule

// File: rtl/adc_cmt_chk.sv
// Checker: temporal properties of the commit engine, bound to the top.
module adc_cmt_chk
    import adc_cmt_pkg::*;
#(
    parameter int NSLOT    = 8,
    parameter int HS_DELAY = 6,
    parameter int SEL_W    = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_wr,
    input logic [7:0]              bus_addr,
    input logic [7:0]              bus_wdata,
    input logic [NSLOT-1:0]        evt_lo_i,
    input logic [NSLOT*SLOT_W-1:0] slot_cfg_o,
    input logic                    hs_flag,
    input logic                    commit_go,
    input slot_t                   staged,
    input logic [SEL_W-1:0]        tgt,
    input logic                    blk_en,
    input logic [NSLOT-1:0]        st_lo
);
    localparam int CW = $clog2(HS_DELAY + 3);

    logic [CW-1:0]    since_q;
    logic [SEL_W-1:0] tgt_q;
    logic [SLOT_W-1:0] sel_slot;

    // Count cycles since the last accepted commit, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_q <= '0;
        else if (commit_go)
            since_q <= CW'(1);
        else if (since_q != '0 && since_q < CW'(HS_DELAY + 2))
            since_q <= since_q + 1'b1;
        tgt_q <= tgt;
    end

    assign sel_slot = slot_cfg_o[tgt_q*SLOT_W +: SLOT_W];

    // R3
    commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_go |=> (sel_slot == $past(staged)));

    // R4
    hs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_flag) |-> (since_q == CW'(HS_DELAY + 1)) ||
            $past(bus_wr && bus_addr == A_HS_CLR && bus_wdata[0]));

    // R6
    disabled_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_REQ && bus_wdata[7] && !blk_en) |=> $stable(slot_cfg_o));

    // R10
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_LO_CLR) |=>
            ((st_lo & $past(bus_wdata[NSLOT-1:0] & ~evt_lo_i)) == '0));
endmodule

bind adc_cmt_top adc_cmt_chk #(.NSLOT(NSLOT), .HS_DELAY(HS_DELAY), .SEL_W(SEL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .evt_lo_i(evt_lo_i), .slot_cfg_o(slot_cfg_o), .hs_flag(hs_flag), .commit_go(commit_go),
    .staged(staged), .tgt(tgt), .blk_en(blk_en), .st_lo(st_lo)
);

// File: tb/adc_cmt_top_tb.sv
module adc_cmt_top_tb;
    import adc_cmt_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NSLOT = 8;
    localparam int HSD   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
    logic [NSLOT-1:0] evt_lo_i = '0, evt_hi_i = '0;
    logic [NSLOT*SLOT_W-1:0] slot_cfg_o;
    logic irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    adc_cmt_top #(.NSLOT(NSLOT), .HS_DELAY(HSD)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_lo_i(evt_lo_i),
        .evt_hi_i(evt_hi_i), .slot_cfg_o(slot_cfg_o), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic slot_t slot_of(input int i);
        return slot_cfg_o[i*SLOT_W +: SLOT_W];
    endfunction

    task automatic wait_cycles(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic stage_full(input logic [7:0] chctl);
        wr(8'h40, 8'h5A); wr(8'h41, chctl); wr(8'h42, 8'hDC); wr(8'h43, 8'h83);
        wr(8'h44, 8'h21); wr(8'h45, 8'hF9); wr(8'h49, 8'h34); wr(8'h4A, 8'h12);
        wr(8'h4B, 8'hCD); wr(8'h4C, 8'hAB); wr(8'h4D, 8'hFF);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        check("R1 slots zero", 128'(slot_cfg_o), 128'h0);
        rd(8'h09, d); check("R1 low status", 128'(d), 128'h0);
        rd(8'h0B, d); check("R1 high status", 128'(d), 128'h0);
        rd(8'h0D, d); check("R1 hs flag", 128'(d), 128'h0);
        rd(8'h46, d); check("R1 enable", 128'(d), 128'h0);
        check("R1 irq", 128'(irq_o), 128'h0);
    endtask

    task automatic t_stage;
        logic [7:0] d;
        stage_full(8'h6B);
        rd(8'h40, d); check("R2 id", 128'(d), 128'h5A);
        rd(8'h41, d); check("R2 chctl mask", 128'(d), 128'h68);
        rd(8'h42, d); check("R2 dig mask", 128'(d), 128'h1C);
        rd(8'h45, d); check("R2 settle mask", 128'(d), 128'h09);
        rd(8'h4A, d); check("R2 low thr hi byte", 128'(d), 128'h12);
        rd(8'h4D, d); check("R2 mctl mask", 128'(d), 128'h83);
    endtask

    task automatic t_commit;
        slot_t e;
        logic [7:0] d;
        e = '{id:8'h5A, interval:2'd2, cal:2'd1, dec:2'd3, avg:8'h83, adc:8'h21,
              settle:4'h9, lo_thr:16'h1234, hi_thr:16'hABCD, meas_en:1'b1, hi_ie:1'b1, lo_ie:1'b1};
        wr(8'h46, 8'h80);
        wr(8'h0D, 8'h01);
        rd(8'h0D, d); check("R4 flag set", 128'(d), 128'h1);
        wr(8'h47, 8'h80);
        check("R3 slot3 copied", 128'(slot_of(3)), 128'(e));
        check("R3 slot2 untouched", 128'(slot_of(2)), 128'h0);
        rd(8'h0D, d); check("R4 flag held after commit", 128'(d), 128'h1);
        wait_cycles(HSD - 1);
        rd(8'h0D, d); check("R4 flag held last cycle", 128'(d), 128'h1);
        wait_cycles(1);
        rd(8'h0D, d); check("R4 flag cleared", 128'(d), 128'h0);
    endtask

    task automatic t_busy;
        logic [7:0] d;
        wr(8'h0D, 8'h01);
        wr(8'h47, 8'h80);
        wr(8'h41, 8'hA0);
        wr(8'h47, 8'h80);
        check("R5 busy request ignored", 128'(slot_of(5)), 128'h0);
        wait_cycles(HSD + 1);
        rd(8'h0D, d); check("R5 flag clear", 128'(d), 128'h0);
        wr(8'h47, 8'h80);
        check("R5 unflagged request ignored", 128'(slot_of(5)), 128'h0);
    endtask

    task automatic t_disabled;
        logic [7:0] d;
        wr(8'h46, 8'h00);
        wr(8'h41, 8'hC0);
        wr(8'h0D, 8'h01);
        wr(8'h47, 8'h80);
        wait_cycles(HSD + 1);
        check("R6 slot6 unchanged", 128'(slot_of(6)), 128'h0);
        rd(8'h0D, d); check("R6 flag kept", 128'(d), 128'h1);
        rd(8'h0E, d); check("R7 clear view shows flag", 128'(d), 128'h1);
        wr(8'h0E, 8'h01);
        rd(8'h0E, d); check("R7 abort clears flag", 128'(d), 128'h0);
        wr(8'h46, 8'h80);
    endtask

    task automatic t_disable_slot;
        slot_t s;
        logic [7:0] d;
        wr(8'h41, 8'h60);
        wr(8'h4D, 8'h00);
        wr(8'h0D, 8'h01);
        wr(8'h47, 8'h80);
        s = slot_of(3);
        check("R8 slot3 enables off", 128'({s.meas_en, s.hi_ie, s.lo_ie}), 128'h0);
        wait_cycles(HSD + 1);
        @(negedge clk); evt_lo_i = 8'h08; evt_hi_i = 8'h08;
        @(negedge clk); evt_lo_i = '0; evt_hi_i = '0;
        rd(8'h09, d); check("R8 disabled slot no low status", 128'(d), 128'h0);
        rd(8'h0B, d); check("R8 disabled slot no high status", 128'(d), 128'h0);
    endtask

    task automatic t_status;
        logic [7:0] d;
        wr(8'h41, 8'h40);
        wr(8'h4D, 8'h81);
        wr(8'h0D, 8'h01);
        wr(8'h47, 8'h80);
        wait_cycles(HSD + 1);
        @(negedge clk); evt_lo_i = 8'h04;
        @(negedge clk); evt_lo_i = '0;
        rd(8'h09, d); check("R9 low status set", 128'(d), 128'h04);
        rd(8'h0A, d); check("R9 low clear view", 128'(d), 128'h04);
        check("R9 irq high", 128'(irq_o), 128'h1);
        @(negedge clk); evt_hi_i = 8'h04;
        @(negedge clk); evt_hi_i = '0;
        rd(8'h0B, d); check("R9 high gated off", 128'(d), 128'h0);
        rd(8'h0A, d);
        wr(8'h0A, d);
        rd(8'h09, d); check("R10 low cleared", 128'(d), 128'h0);
        check("R9 irq low", 128'(irq_o), 128'h0);
        wr(8'h0B, 8'h81);
        rd(8'h0C, d); check("R10 high software set", 128'(d), 128'h81);
        wr(8'h0C, 8'h01);
        rd(8'h0B, d); check("R10 high partial clear", 128'(d), 128'h80);
    endtask

    initial begin
        wait_cycles(3);
        rst_n = 1'b1;
        wait_cycles(1);
        t_reset();
        t_stage();
        t_commit();
        t_busy();
        t_disabled();
        t_disable_slot();
        t_status();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule